// File: doc/BRIEF.md
# Overlapped Loop Iteration Sequencer

The sequencer drives a spatially pipelined loop body. After a start pulse it launches one iteration every II cycles into a chain of up to eight stages. Each launched iteration then moves up one stage per issue slot, so several iterations can be in flight at once. Every iteration follows the same schedule. While the pipeline fills, the stages that no iteration has reached yet stay quiet because of their own occupancy predicates. No separate fill logic is used. The stage enables and a sub-cycle phase count together tell each datapath module when to fire.

The datapath can raise a loop-exit flag from any stage. Flags are sampled on the final phase of each slot. When an exit is taken, the iteration that raised it runs on through the remaining stages and commits. Younger iterations, which were started speculatively, are removed and never commit, and no further iterations are issued. When the exiting iteration leaves the last stage, the block pulses done and reports the stage index of the exit that was taken. The host uses that index to pick up the matching live values.

Top module: `loop_pipe_seq`

## Requirements
- R1: After reset, busy, done, commit, phase and all stage enables are 0.
- R2: A start pulse while idle latches ii_cfg and stages_cfg, raises busy on the next cycle, and places iteration 0 in stage 0 (stage_en bit 0) with phase 0.
- R3: While no exit has been taken, a new iteration enters stage 0 every II cycles, and each occupied stage passes its iteration to the next stage every II cycles.
- R4: Stage enable bits at or above the latched stage count are never set. During fill, stage s stays disabled until iteration 0 reaches it, which happens s slots after the launch.
- R5: While busy, phase counts 0,1,…,II-1 and then wraps to 0. When idle, phase is 0.
- R6: exit_req bit s is acted on only on the last phase of a slot, and only when stage_en bit s is set. At any other time it has no effect.
- R7: When an exit is taken, the exiting iteration keeps advancing. All younger iterations vanish from stage_en starting with the next slot, and stage 0 receives no new iteration.
- R8: When several enabled stages raise exit_req in the same sampling cycle, the highest-numbered stage wins, because it holds the oldest iteration. exit_code is the 3-bit binary index of the winning stage.
- R9: commit is high for one cycle on the last phase of a slot exactly when the last configured stage is occupied. Over a run, the number of commits equals the exiting iteration's number plus one.
- R10: done is a single-cycle pulse. It comes in the cycle after the exiting iteration's final slot ends, and busy is low in that same cycle. exit_code holds its value until the next start.
- R11: A start pulse or a configuration change while busy has no effect on the running schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse; sampled only while idle |
| ii_cfg | input | 4 | Initiation interval, 1 to 8 cycles |
| stages_cfg | input | 4 | Stage count, 1 to 8 |
| exit_req | input | 8 | Per-stage exit-condition flags from the datapath |
| stage_en | output | 8 | Per-stage occupancy predicates |
| phase | output | 3 | Cycle index within the current slot |
| commit | output | 1 | An iteration leaves the last stage |
| done | output | 1 | One-cycle loop-finished pulse |
| exit_code | output | 3 | Index of the stage whose exit was taken |
| busy | output | 1 | Loop in progress |

## Verification
The assertions assume that ii_cfg and stages_cfg are within 1..8 whenever a start is accepted. They also assume that the datapath eventually raises an exit from some occupied stage, since otherwise the loop never ends and done never comes. The stimulus draws configurations only from the legal range and plans a concrete exiting iteration and stage for every run. It then feeds random noise on exit_req during non-sampling phases and on unoccupied stages, and random start and configuration values while busy. This noise shows that such inputs leave the schedule alone.

// File: rtl/loop_pipe_seq.sv
module loop_pipe_seq #(
  parameter int MAX_STAGES = 8,
  parameter int MAX_II     = 8,
  parameter int EXIT_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(MAX_II+1)-1:0]   ii_cfg,
  input  logic [$clog2(MAX_STAGES+1)-1:0] stages_cfg,
  input  logic [MAX_STAGES-1:0]         exit_req,
  output logic [MAX_STAGES-1:0]         stage_en,
  output logic [$clog2(MAX_II)-1:0]     phase,
  output logic                          commit,
  output logic                          done,
  output logic [EXIT_W-1:0]             exit_code,
  output logic                          busy
);
  localparam int CW  = $clog2(MAX_II+1);
  localparam int PW  = $clog2(MAX_II);
  localparam int SCW = $clog2(MAX_STAGES+1);
  localparam int S   = MAX_STAGES;

  logic [CW-1:0]     ii_q;
  logic [SCW-1:0]    nst_q;
  logic [PW-1:0]     ph_q;
  logic [S-1:0]      vld_q;
  logic              busy_q, drain_q, done_q;
  logic [EXIT_W-1:0] code_q;

  logic [S-1:0]      stg_mask, hits, keep, vld_nxt;
  logic              slot_end, hit_any, last_occ, issue, finish;
  logic [EXIT_W-1:0] hit_idx;

  assign slot_end = busy_q && (CW'(ph_q) + CW'(1) == ii_q);
  assign hits     = exit_req & vld_q & {S{slot_end}};
  assign hit_any  = |hits;

  always_comb begin
    hit_idx  = '0;
    last_occ = 1'b0;
    for (int s = 0; s < S; s++) begin
      stg_mask[s] = SCW'(s) < nst_q;
      if (hits[s]) hit_idx = EXIT_W'(s);
      if (SCW'(s) + SCW'(1) == nst_q && vld_q[s]) last_occ = 1'b1;
    end
    for (int s = 0; s < S; s++)
      keep[s] = !hit_any || (EXIT_W'(s) >= hit_idx);
  end

  assign issue   = !drain_q && !hit_any;
  assign vld_nxt = (((vld_q & keep) << 1) | S'(issue)) & stg_mask;
  assign finish  = slot_end && (drain_q || hit_any) && (vld_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      drain_q <= 1'b0;
      done_q  <= 1'b0;
      ph_q    <= '0;
      vld_q   <= '0;
      ii_q    <= CW'(1);
      nst_q   <= SCW'(1);
      code_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          ii_q    <= ii_cfg;
          nst_q   <= stages_cfg;
          ph_q    <= '0;
          vld_q   <= S'(1);
          drain_q <= 1'b0;
          code_q  <= '0;
        end
      end else if (slot_end) begin
        ph_q  <= '0;
        vld_q <= vld_nxt;
        if (hit_any) begin
          drain_q <= 1'b1;
          code_q  <= hit_idx;
        end
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        ph_q <= ph_q + PW'(1);
      end
    end
  end

  assign stage_en  = vld_q;
  assign phase     = ph_q;
  assign commit    = slot_end && last_occ;
  assign done      = done_q;
  assign exit_code = code_q;
  assign busy      = busy_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (stage_en == '0 && phase == '0 && !commit));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy && stage_en != '0);
  // R7
  no_issue_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && hit_any) |=> !stage_en[0]);
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ii_q) && $stable(nst_q)));
endmodule

// File: tb/loop_pipe_seq_tb.sv
module loop_pipe_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] ii_cfg = 4'd1;
  logic [3:0] stages_cfg = 4'd1;
  logic [S-1:0] exit_req = '0;
  logic [S-1:0] stage_en;
  logic [2:0] phase;
  logic       commit, done, busy;
  logic [2:0] exit_code;

  loop_pipe_seq u_dut (.clk(clk), .rst_n(rst_n), .start(start), .ii_cfg(ii_cfg),
    .stages_cfg(stages_cfg), .exit_req(exit_req), .stage_en(stage_en), .phase(phase),
    .commit(commit), .done(done), .exit_code(exit_code), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  int m_busy, m_ph, m_ii, m_ns, m_drain, m_done, m_code, m_next;
  int m_it [S];
  int commits_seen;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_en();
    int v = 0;
    for (int s = 0; s < S; s++) if (m_it[s] >= 0) v |= (1 << s);
    return v;
  endfunction

  function automatic bit m_slot_end();
    return m_busy != 0 && m_ph == m_ii - 1;
  endfunction

  task automatic compare();
    bit ec = m_slot_end() && m_it[m_ns-1] >= 0;
    // R3 R4 R7: stage predicates
    chk(stage_en == S'(exp_en()), "R3/R4/R7 stage_en", int'(stage_en), exp_en());
    // R5: phase
    chk(int'(phase) == (m_busy ? m_ph : 0), "R5 phase", int'(phase), m_ph);
    // R9: commit
    chk(commit == ec, "R9 commit", int'(commit), int'(ec));
    // R10: done / busy
    chk(done == m_done[0], "R10 done", int'(done), m_done);
    chk(busy == m_busy[0], "R2/R10 busy", int'(busy), m_busy);
    if (!m_busy) chk(int'(exit_code) == m_code, "R10 exit_code hold", int'(exit_code), m_code);
    if (commit) commits_seen++;
  endtask

  task automatic model_step();
    int win = -1;
    bit empty = 1;
    m_done = 0;
    if (!m_busy) begin
      if (start) begin
        m_busy = 1; m_ii = int'(ii_cfg); m_ns = int'(stages_cfg); m_ph = 0;
        foreach (m_it[s]) m_it[s] = -1;
        m_it[0] = 0; m_next = 1; m_drain = 0; m_code = 0;
      end
    end else if (!m_slot_end()) begin
      m_ph++;
    end else begin
      for (int s = 0; s < m_ns; s++) if (m_it[s] >= 0 && exit_req[s]) win = s;
      if (win >= 0) begin
        m_drain = 1; m_code = win;
        for (int t = 0; t < S; t++) if (m_it[t] > m_it[win]) m_it[t] = -1;
      end
      for (int s = m_ns - 1; s > 0; s--) m_it[s] = m_it[s-1];
      if (!m_drain) begin m_it[0] = m_next; m_next++; end
      else m_it[0] = -1;
      for (int s = 0; s < S; s++) if (m_it[s] >= 0) empty = 0;
      if (m_drain && empty) begin m_busy = 0; m_done = 1; end
      m_ph = 0;
    end
  endtask

  task automatic drive_exits(input int x, input int k, input bit dual);
    logic [S-1:0] v = S'($urandom);
    if (m_slot_end()) begin
      for (int s = 0; s < S; s++) begin
        if (m_it[s] >= 0)
          v[s] = (m_it[s] == x && s == k) || (dual && m_it[s] == x + 1 && s == k - 1);
      end
    end
    exit_req = v;
  endtask

  task automatic run_loop(input int ii, input int ns, input int x, input int k,
                          input bit dual, input bit noisy);
    int guard = 0;
    @(negedge clk);
    compare();
    start = 1; ii_cfg = 4'(ii); stages_cfg = 4'(ns); exit_req = S'($urandom);
    commits_seen = 0;
    model_step();
    do begin
      @(negedge clk);
      compare();
      if (m_done) begin
        // R9: total commits
        chk(commits_seen == x + 1, "R9 commit total", commits_seen, x + 1);
        // R8: exit code = winning stage
        chk(int'(exit_code) == k, "R8 exit_code", int'(exit_code), k);
      end
      // R11: start and cfg noise while busy
      start = noisy ? 1'($urandom) : 1'b0;
      if (start && !m_busy) start = 1'b0;
      ii_cfg = noisy ? 4'($urandom_range(1, 8)) : 4'(ii);
      stages_cfg = noisy ? 4'($urandom_range(1, 8)) : 4'(ns);
      // R6: noise outside sampling phase and on empty stages
      drive_exits(x, k, dual);
      model_step();
      guard++;
    end while (!m_done && guard < 2000);
    repeat (3) begin
      @(negedge clk);
      compare();
      start = 1'b0; exit_req = S'($urandom);
      model_step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    m_busy = 0; m_ph = 0; m_ii = 1; m_ns = 1; m_drain = 0; m_done = 0; m_code = 0; m_next = 0;
    foreach (m_it[s]) m_it[s] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && commit == 0 && stage_en == '0 && phase == '0,
        "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    // directed corners
    run_loop(1, 1, 0, 0, 0, 0);   // R2 minimal pipe
    run_loop(8, 8, 3, 7, 0, 0);   // R4 full fill, exit at last stage
    run_loop(3, 5, 4, 2, 1, 0);   // R8 simultaneous exits
    run_loop(2, 4, 0, 0, 0, 1);   // R7 first iteration exits at stage 0
    run_loop(1, 8, 5, 6, 1, 1);   // R3 R11 back-to-back issue with noise
    for (int n = 0; n < 40; n++) begin
      int ii = $urandom_range(1, 8);
      int ns = $urandom_range(1, 8);
      int x  = $urandom_range(0, 5);
      int k  = $urandom_range(0, ns - 1);
      bit dual = (k > 0) && 1'($urandom);
      run_loop(ii, ns, x, k, dual, 1'($urandom));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule